// File: doc/BRIEF.md
# Return-to-zero bipolar serial word transmitter

The block pulls 31-bit words from an external FIFO, adds a parity bit to form a 32-bit frame and sends each frame serially on a complementary pair of return-to-zero lines. Every bit time has a data phase followed by a null phase of equal length. A gap of inactive line time separates consecutive words. All timing is counted in cycles of the transmit clock. One rate-select input picks the fast or the slow timing set. The rate is captured when a word is fetched, so each word goes out with one timing set from start to end.

Words are sent back to back for as long as the enable input stays high and the FIFO holds data. The ready flag rises once the last word and its gap have finished and the FIFO is empty. Lowering the enable while a word is being sent cuts that word short, and the word is lost. The host therefore keeps the enable high until the ready flag rises.

A self-test control routes the line pair to two loopback outputs. The first loopback pair carries the line values unchanged. The second pair carries the complement, with the two lines swapped. The normal lines keep driving during self-test.

Top module: `rzw_tx`

## Requirements
- R1: During and right after reset both line outputs and all loopback outputs are 0 and `fifo_pop` is 0. `tx_ready` is 1 whenever the sequencer is idle and `fifo_empty` is 1.
- R2: When the sequencer is idle, `tx_en` is 1 and `fifo_empty` is 0, `fifo_pop` is 1 in that same cycle. The data phase of frame bit 0 is on the lines from the next clock edge.
- R3: During a data phase a one drives `line_hi`=1 and `line_lo`=0, and a zero drives `line_hi`=0 and `line_lo`=1. In every other cycle both lines are 0. Frame bits go out in the order word bit 0 through bit 30, then the parity bit as the 32nd bit.
- R4: With `parity_even`=0 the 32-bit frame holds an odd number of ones. With `parity_even`=1 it holds an even number. The setting is captured at fetch.
- R5: With `rate_low`=0 each bit has a 5-cycle data phase and a 5-cycle null phase. After the null phase of bit 32 the lines stay inactive for 40 more cycles before the next word can start.
- R6: With `rate_low`=1 the data and null phases are each 40 cycles, and the word gap is 320 cycles.
- R7: `rate_low` is captured only when a word is fetched. Changing it mid-word does not change that word's timing. The next fetched word uses the new value.
- R8: While `tx_en` stays 1 and the FIFO holds words, the next word is fetched at the end of the gap, so its first data phase follows the previous last data phase after exactly one null phase plus one gap. `tx_ready` is 0 while words are in flight.
- R9: If `tx_en` is 0 during a data or null phase, both lines are 0 from the next cycle on. The unfinished word is dropped and never resent. The FIFO is not read again until `tx_en` returns to 1.
- R10: With `selftest_n`=0, `lb_true_hi`/`lb_true_lo` equal `line_hi`/`line_lo` and `lb_comp_hi`/`lb_comp_lo` equal `line_lo`/`line_hi`, while the lines keep driving. With `selftest_n`=1 all four loopback outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmission enable |
| rate_low | input | 1 | 1 selects slow timing, 0 fast timing |
| parity_even | input | 1 | 1 selects even frame parity, 0 odd |
| selftest_n | input | 1 | 0 enables the loopback outputs |
| fifo_empty | input | 1 | External FIFO holds no word |
| fifo_word | input | 31 | Word at the head of the FIFO |
| fifo_pop | output | 1 | Removes the head word this cycle |
| line_hi | output | 1 | Positive line of the RZ pair |
| line_lo | output | 1 | Negative line of the RZ pair |
| lb_true_hi | output | 1 | Loopback 1, positive (as sent) |
| lb_true_lo | output | 1 | Loopback 1, negative (as sent) |
| lb_comp_hi | output | 1 | Loopback 2, positive (complemented) |
| lb_comp_lo | output | 1 | Loopback 2, negative (complemented) |
| tx_ready | output | 1 | Idle with nothing left to send |

## Verification
A slip in the phase counter shows up at the next line transition as a data or null run of the wrong length, so a timing fault is seen within one bit time. A wrong bit index or shift is seen once the frame completes, as a 32-bit frame that differs from the scoreboard entry, or as a frame that never ends. A rate latched at the wrong moment changes the run lengths of the word that should have been unaffected. An abort that fails to clear the state leaves activity on the lines, or sends the dropped word, during the pause that the bench observes before it re-enables.

// File: rtl/rzw_pkg.sv
package rzw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_NULL = 2'd2,
        ST_GAP  = 2'd3
    } rzw_state_e;

endpackage

// File: rtl/rzw_parity.sv
module rzw_parity #(
    parameter int WORD_W = 31
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic              even_i,
    output logic              par_o
);

    // frame ones count is odd when even_i = 0, even when even_i = 1
    always_comb begin
        par_o = (^word_i) ^ ~even_i;
    end

endmodule

// File: rtl/rzw_loop.sv
module rzw_loop #(
    parameter int NRX = 2
) (
    input  logic           selftest_n,
    input  logic           hi_i,
    input  logic           lo_i,
    output logic [NRX-1:0] rx_hi,
    output logic [NRX-1:0] rx_lo
);

    for (genvar i = 0; i < NRX; i++) begin : g_rx
        if ((i % 2) == 0) begin : g_true
            always_comb begin
                rx_hi[i] = ~selftest_n & hi_i;
                rx_lo[i] = ~selftest_n & lo_i;
            end
        end else begin : g_comp
            always_comb begin
                rx_hi[i] = ~selftest_n & lo_i;
                rx_lo[i] = ~selftest_n & hi_i;
            end
        end
    end

endmodule

// File: rtl/rzw_seq.sv
module rzw_seq
    import rzw_pkg::*;
#(
    parameter int WORD_W  = 31,
    parameter int HS_HALF = 5,
    parameter int LS_HALF = 40,
    parameter int HS_GAP  = 40,
    parameter int LS_GAP  = 320
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              rate_low,
    input  logic              fifo_empty,
    input  logic [WORD_W:0]   frame_i,
    output logic              fifo_pop,
    output logic              line_hi,
    output logic              line_lo,
    output logic              tx_ready
);

    localparam int FRAME_W = WORD_W + 1;
    localparam int IDX_W   = $clog2(FRAME_W);
    localparam int MAX_H   = (HS_HALF > LS_HALF) ? HS_HALF : LS_HALF;
    localparam int MAX_G   = (HS_GAP > LS_GAP) ? HS_GAP : LS_GAP;
    localparam int MAX_C   = (MAX_H > MAX_G) ? MAX_H : MAX_G;
    localparam int CNT_W   = $clog2(MAX_C + 1);

    localparam logic [CNT_W-1:0] HS_H = CNT_W'(HS_HALF - 1);
    localparam logic [CNT_W-1:0] LS_H = CNT_W'(LS_HALF - 1);
    localparam logic [CNT_W-1:0] HS_G = CNT_W'(HS_GAP - 1);
    localparam logic [CNT_W-1:0] LS_G = CNT_W'(LS_GAP - 1);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_W - 1);

    typedef struct packed {
        rzw_state_e         st;
        logic [CNT_W-1:0]   cnt;
        logic [IDX_W-1:0]   bitn;
        logic [FRAME_W-1:0] sh;
        logic               low;
    } seq_t;

    seq_t q, d;
    logic start;
    logic fetch_ok;

    always_comb begin
        d        = q;
        fetch_ok = tx_en & ~fifo_empty;
        start    = 1'b0;
        case (q.st)
            ST_IDLE: begin
                start = fetch_ok;
            end
            ST_DATA: begin
                if (!tx_en) begin
                    d.st = ST_IDLE;
                end else if (q.cnt == '0) begin
                    d.st  = ST_NULL;
                    d.cnt = q.low ? LS_H : HS_H;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_NULL: begin
                if (!tx_en) begin
                    d.st = ST_IDLE;
                end else if (q.cnt == '0) begin
                    if (q.bitn == LAST) begin
                        d.st  = ST_GAP;
                        d.cnt = q.low ? LS_G : HS_G;
                    end else begin
                        d.st   = ST_DATA;
                        d.bitn = q.bitn + 1'b1;
                        d.sh   = q.sh >> 1;
                        d.cnt  = q.low ? LS_H : HS_H;
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_GAP: begin
                if (q.cnt == '0) begin
                    d.st  = ST_IDLE;
                    start = fetch_ok;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (start) begin
            d.st   = ST_DATA;
            d.low  = rate_low;
            d.cnt  = rate_low ? LS_H : HS_H;
            d.bitn = '0;
            d.sh   = frame_i;
        end
        fifo_pop = start;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cnt: '0, bitn: '0, sh: '0, low: 1'b0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        line_hi  = (q.st == ST_DATA) &  q.sh[0];
        line_lo  = (q.st == ST_DATA) & ~q.sh[0];
        tx_ready = (q.st == ST_IDLE) & fifo_empty;
    end

    // R2
    fetch_to_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> (q.st == ST_DATA && q.bitn == '0));

    // R7
    rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE && $past(q.st) != ST_IDLE && !$past(fifo_pop)) |-> $stable(q.low));

    // R3
    bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.st) == ST_NULL && q.st == ST_DATA) |-> (q.bitn == IDX_W'($past(q.bitn) + 1'b1)));

    // R5
    gap_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_GAP && $past(q.st) != ST_GAP) |-> ($past(q.bitn) == LAST));

    // R9
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && (q.st == ST_DATA || q.st == ST_NULL)) |=> (q.st == ST_IDLE && !line_hi && !line_lo));

endmodule

// File: rtl/rzw_tx.sv
module rzw_tx #(
    parameter int WORD_W  = 31,
    parameter int HS_HALF = 5,
    parameter int LS_HALF = 40,
    parameter int HS_GAP  = 40,
    parameter int LS_GAP  = 320
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              rate_low,
    input  logic              parity_even,
    input  logic              selftest_n,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_word,
    output logic              fifo_pop,
    output logic              line_hi,
    output logic              line_lo,
    output logic              lb_true_hi,
    output logic              lb_true_lo,
    output logic              lb_comp_hi,
    output logic              lb_comp_lo,
    output logic              tx_ready
);

    localparam int NRX = 2;

    logic           par_bit;
    logic [WORD_W:0] frame;
    logic [NRX-1:0] rx_hi;
    logic [NRX-1:0] rx_lo;

    rzw_parity #(.WORD_W(WORD_W)) u_par (
        .word_i (fifo_word),
        .even_i (parity_even),
        .par_o  (par_bit)
    );

    always_comb begin
        frame = {par_bit, fifo_word};
    end

    rzw_seq #(
        .WORD_W  (WORD_W),
        .HS_HALF (HS_HALF),
        .LS_HALF (LS_HALF),
        .HS_GAP  (HS_GAP),
        .LS_GAP  (LS_GAP)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .rate_low   (rate_low),
        .fifo_empty (fifo_empty),
        .frame_i    (frame),
        .fifo_pop   (fifo_pop),
        .line_hi    (line_hi),
        .line_lo    (line_lo),
        .tx_ready   (tx_ready)
    );

    rzw_loop #(.NRX(NRX)) u_loop (
        .selftest_n (selftest_n),
        .hi_i       (line_hi),
        .lo_i       (line_lo),
        .rx_hi      (rx_hi),
        .rx_lo      (rx_lo)
    );

    always_comb begin
        lb_true_hi = rx_hi[0];
        lb_true_lo = rx_lo[0];
        lb_comp_hi = rx_hi[1];
        lb_comp_lo = rx_lo[1];
    end

endmodule

// File: tb/rzw_tx_tb.sv
`timescale 1ns/1ps
module rzw_tx_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b0;
    logic rate_low = 1'b0;
    logic parity_even = 1'b0;
    logic selftest_n = 1'b1;
    logic fifo_empty;
    logic [30:0] fifo_word;
    logic fifo_pop, line_hi, line_lo, tx_ready;
    logic lb_true_hi, lb_true_lo, lb_comp_hi, lb_comp_lo;

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // bench FIFO model
    logic [30:0] fmem [0:15];
    int wrp = 0;
    int rdp = 0;
    assign fifo_empty = (wrp == rdp);
    assign fifo_word  = fmem[rdp[3:0]];
    always @(posedge clk) if (fifo_pop && (wrp != rdp)) rdp <= rdp + 1;

    rzw_tx u_dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rate_low(rate_low),
        .parity_even(parity_even), .selftest_n(selftest_n),
        .fifo_empty(fifo_empty), .fifo_word(fifo_word), .fifo_pop(fifo_pop),
        .line_hi(line_hi), .line_lo(line_lo),
        .lb_true_hi(lb_true_hi), .lb_true_lo(lb_true_lo),
        .lb_comp_hi(lb_comp_hi), .lb_comp_lo(lb_comp_lo),
        .tx_ready(tx_ready)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard queues
    logic [31:0] exp_q [$];
    bit          low_q [$];

    task automatic fifo_put(input logic [30:0] w);
        fmem[wrp[3:0]] = w;
        wrp = wrp + 1;
    endtask

    task automatic expect_word(input logic [30:0] w, input bit even, input bit low);
        logic p;
        p = even ? (^w) : ~(^w);
        exp_q.push_back({p, w});
        low_q.push_back(low);
    endtask

    task automatic push(input logic [30:0] w, input bit even, input bit low);
        fifo_put(w);
        expect_word(w, even, low);
    endtask

    // monitor
    bit mon_on = 1'b1;
    int nb, idle_len, act_len, prev_hg, half;
    bit prev_act, cur, act;
    logic [31:0] got;

    always @(negedge clk) begin
        if (!rst_n || !mon_on) begin
            nb = 0; idle_len = 100000; act_len = 0; prev_act = 0; got = '0;
        end else begin
            act = line_hi | line_lo;
            if (line_hi && line_lo) chk(1'b0, "R3 both lines", 64'd3, 64'd1);
            if (act) begin
                if (!prev_act) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R8 unexpected line activity", 64'd1, 64'd0);
                    end else begin
                        half = low_q[0] ? 40 : 5;
                        if (nb > 0)
                            chk(idle_len == half, "R5/R6 null phase length", 64'(idle_len), 64'(half));
                        else if (idle_len < 1000)
                            chk(idle_len == prev_hg, "R8 word gap length", 64'(idle_len), 64'(prev_hg));
                    end
                    cur = line_hi;
                    act_len = 0;
                end
                act_len++;
                idle_len = 0;
            end else begin
                if (prev_act && exp_q.size() > 0) begin
                    half = low_q[0] ? 40 : 5;
                    chk(act_len == half, "R5/R6 data phase length", 64'(act_len), 64'(half));
                    got[nb] = cur;
                    nb++;
                    if (nb == 32) begin
                        chk(got == exp_q[0], "R3/R4 frame bits", 64'(got), 64'(exp_q[0]));
                        prev_hg = half + (low_q[0] ? 320 : 40);
                        void'(exp_q.pop_front());
                        void'(low_q.pop_front());
                        nb = 0;
                    end
                end
                idle_len++;
            end
            prev_act = act;
        end
    end

    // loopback checker, R10
    always @(negedge clk) begin
        if (rst_n) begin
            if (!selftest_n)
                chk({lb_true_hi, lb_true_lo, lb_comp_hi, lb_comp_lo} == {line_hi, line_lo, line_lo, line_hi},
                    "R10 loopback active", 64'({lb_true_hi, lb_true_lo, lb_comp_hi, lb_comp_lo}),
                    64'({line_hi, line_lo, line_lo, line_hi}));
            else
                chk({lb_true_hi, lb_true_lo, lb_comp_hi, lb_comp_lo} == 4'b0,
                    "R10 loopback off", 64'({lb_true_hi, lb_true_lo, lb_comp_hi, lb_comp_lo}), 64'd0);
        end
    end

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    task automatic drain;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (1100) @(negedge clk);
    endtask

    int actives;

    initial begin
        repeat (3) @(negedge clk);
        chk({line_hi, line_lo, fifo_pop} == 3'b0, "R1 outputs in reset", 64'({line_hi, line_lo, fifo_pop}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({line_hi, line_lo, fifo_pop} == 3'b0, "R1 outputs after reset", 64'({line_hi, line_lo, fifo_pop}), 64'd0);
        chk(tx_ready == 1'b1, "R1 ready when idle", 64'(tx_ready), 64'd1);

        // fetch latency, first bit, odd parity, fast rate
        tx_en = 1'b1;
        @(negedge clk);
        push(31'h1234_5678, 1'b0, 1'b0);
        #1;
        chk(fifo_pop == 1'b1, "R2 pop same cycle", 64'(fifo_pop), 64'd1);
        @(negedge clk);
        chk({line_hi, line_lo} == 2'b01, "R2/R3 bit 0 next cycle", 64'({line_hi, line_lo}), 64'd1);
        drain();

        // back to back, even parity
        parity_even = 1'b1;
        push(31'h7FFF_FFFF, 1'b1, 1'b0);
        push(31'h0000_0000, 1'b1, 1'b0);
        push(31'h2D2D_52D2, 1'b1, 1'b0);
        repeat (100) @(negedge clk);
        chk(tx_ready == 1'b0, "R8 ready low in burst", 64'(tx_ready), 64'd0);
        drain();
        chk(tx_ready == 1'b1, "R8 ready after drain", 64'(tx_ready), 64'd1);

        // slow rate, two words
        parity_even = 1'b0;
        rate_low = 1'b1;
        push(31'h1357_9BDF, 1'b0, 1'b1);
        push(31'h6420_ECA8, 1'b0, 1'b1);
        drain();

        // rate change mid word
        rate_low = 1'b0;
        push(31'h0F0F_00FF, 1'b0, 1'b0);
        push(31'h5555_AAAA, 1'b0, 1'b1);
        repeat (20) @(negedge clk);
        rate_low = 1'b1;
        drain();
        rate_low = 1'b0;

        // self test
        selftest_n = 1'b0;
        push(31'h3C3C_C3C3, 1'b0, 1'b0);
        drain();
        selftest_n = 1'b1;

        // abort mid word
        mon_on = 1'b0;
        fifo_put(31'h7777_1111);
        fifo_put(31'h0ABC_DEF1);
        repeat (30) @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        chk({line_hi, line_lo} == 2'b00, "R9 lines idle after abort", 64'({line_hi, line_lo}), 64'd0);
        actives = 0;
        repeat (1100) begin
            @(negedge clk);
            if (line_hi || line_lo) actives++;
        end
        chk(actives == 0, "R9 no activity while disabled", 64'(actives), 64'd0);
        chk(fifo_empty == 1'b0, "R9 second word not fetched", 64'(fifo_empty), 64'd0);
        chk(tx_ready == 1'b0, "R9 ready low with word queued", 64'(tx_ready), 64'd0);
        expect_word(31'h0ABC_DEF1, 1'b0, 1'b0);
        mon_on = 1'b1;
        @(negedge clk);
        tx_en = 1'b1;
        drain();
        chk(exp_q.size() == 0, "R9 only next word sent", 64'(exp_q.size()), 64'd0);

        summary();
        $finish;
    end

endmodule